// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises a host processor by demanding a periodic restart that falls inside a time window. Software programs a start-of-window setting and an end-of-window setting, then writes a 4-bit key that arms the timer with those settings. A correct key that arrives inside the window starts a fresh count. A key that arrives before the window opens is an early fault. If the window closes with no key written, that is a late fault. Either fault, when the timer is enabled, sets its own sticky flag and raises a reset request for a fixed number of time units.

Time advances only on a one-cycle `tick` pulse from outside, nominally one per millisecond. The start setting counts in units of `START_STEP` ticks, with a default of 25. The end setting counts in units of `END_STEP` ticks, with a default of 60. The reset request lasts `RST_TICKS` ticks. Software reaches four byte-wide registers through a simple write strobe and a combinational read port.

Register layout: address 0 holds the flags, with early in bit 1 and late in bit 0. Address 1 takes the restart key and always reads 0. Address 2 holds the start setting in bits 4:0. Address 3 holds the end setting in bits 4:0 and the enable in bit 7.

Top module: `window_watchdog`

## Requirements
- R1: After `rst_n` is low, all four registers read 0 and `wdt_rst` is low.
- R2: Address 2 stores bits 4:0 of a write. Address 3 stores bits 4:0 and bit 7. Unused bits read 0, and address 1 always reads 0.
- R3: A write to address 1 whose low nibble is not 1010b has no effect. It neither restarts the count nor loads new settings.
- R4: A write to address 1 with low nibble 1010b restarts the count from 0 and copies the start and end settings into the active timer. The upper nibble of that write is ignored.
- R5: When enabled with a nonzero active end value E, going E*END_STEP ticks after a restart with no key raises `wdt_rst` and sets the late flag (bit 0).
- R6: When enabled with a nonzero active end value, a key written after fewer than S*START_STEP ticks raises `wdt_rst` and sets the early flag (bit 1). S is the active start value.
- R7: `wdt_rst` stays high for exactly RST_TICKS ticks and then falls. Keys written during that time are ignored. Counting restarts from 0 when the request is released.
- R8: With the enable clear, the count still runs and wraps at the end value, but no flag is set and `wdt_rst` stays low.
- R9: An active end value of 0 stops the timer. No early or late fault occurs.
- R10: The flags stay set until software writes 1 to the flag's bit at address 0. Writing 0 to a bit leaves that flag unchanged.
- R11: A key written at or after S*START_STEP ticks, and before the window closes, causes no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wdt_rst | output | 1 | Reset request, active high |

## Verification
The early-fault boundary is the hardest case to reach. It needs a nonzero start value that is already active, which can only come from an earlier key, followed by a second key at an exact tick count. The bench reaches it in a set order:
- It resets the block, so the active start value is 0.
- It writes the settings and sends a first key, which can never be early.
- It steps single ticks up to each elapsed count on both sides of the boundary.
- It sends the second key and compares the reset request and the flags with `elapsed < S*START_STEP`.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int START_STEP = 25,
  parameter int END_STEP   = 60,
  parameter int RST_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wdt_rst
);
  localparam int MAXSTEP = (START_STEP > END_STEP) ? START_STEP : END_STEP;
  localparam int CW = $clog2(31 * MAXSTEP + 2);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam logic [3:0] KEY = 4'b1010;
  localparam logic [1:0] A_FLAG = 2'd0, A_KEY = 2'd1, A_START = 2'd2, A_END = 2'd3;

  logic [4:0]    start_set, end_set, start_act, end_act;
  logic          en, early_f, late_f, rst_q;
  logic [CW-1:0] elapsed, start_lim, end_lim;
  logic [RW-1:0] rst_cnt;
  logic          unused_bits;

  assign unused_bits = ^wdata[6:5];
  assign start_lim = CW'(start_act * START_STEP);
  assign end_lim   = CW'(end_act * END_STEP);

  wire armed     = end_act != 5'd0;
  wire key_wr    = wr_en && addr == A_KEY && wdata[3:0] == KEY && !rst_q;
  wire early_hit = key_wr && en && armed && elapsed < start_lim;
  wire restart   = key_wr && !early_hit;
  wire late_hit  = tick && armed && !rst_q && !key_wr && (elapsed + CW'(1)) == end_lim;
  wire fault     = early_hit || (late_hit && en);
  wire flag_wr   = wr_en && addr == A_FLAG;

  assign wdt_rst = rst_q;

  always_comb begin
    case (addr)
      A_FLAG:  rdata = {6'b0, early_f, late_f};
      A_START: rdata = {3'b0, start_set};
      A_END:   rdata = {en, 2'b0, end_set};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_set <= '0;
      end_set   <= '0;
      en        <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_START) start_set <= wdata[4:0];
      if (addr == A_END) begin
        end_set <= wdata[4:0];
        en      <= wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_act <= '0;
      end_act   <= '0;
    end else if (restart) begin
      start_act <= start_set;
      end_act   <= end_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (rst_q || key_wr || !armed)
      elapsed <= '0;
    else if (tick)
      elapsed <= late_hit ? '0 : elapsed + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_f <= 1'b0;
      late_f  <= 1'b0;
    end else begin
      early_f <= early_hit || (early_f && !(flag_wr && wdata[1]));
      late_f  <= (late_hit && en) || (late_f && !(flag_wr && wdata[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      rst_cnt <= '0;
    end else if (fault) begin
      rst_q   <= 1'b1;
      rst_cnt <= '0;
    end else if (rst_q && tick) begin
      if (rst_cnt == RW'(RST_TICKS - 1)) begin
        rst_q   <= 1'b0;
        rst_cnt <= '0;
      end else begin
        rst_cnt <= rst_cnt + RW'(1);
      end
    end
  end

  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_KEY && wdata[3:0] != KEY) |=> ($stable(start_act) && $stable(end_act)));

  p_elapsed_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_act != 5'd0) |-> (elapsed < end_lim));

  p_rst_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (early_f || late_f));

  p_rst_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !tick) |=> rst_q);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rst_q) |=> !rst_q);

  p_zero_end_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_act == 5'd0 && !rst_q) |=> !rst_q);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (early_f && !(flag_wr && wdata[1])) |=> early_f);
endmodule

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;
  localparam int SS = 2, ES = 3, RT = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wdt_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  window_watchdog #(.START_STEP(SS), .END_STEP(ES), .RST_TICKS(RT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic setup(logic [4:0] s, logic [4:0] e, bit en);
    do_reset();
    wr(2'd2, {3'b0, s});
    wr(2'd3, {en, 2'b0, e});
    wr(2'd1, 8'h0A);
  endtask

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1", d, 0); end
    chk("R1 wdt_rst", wdt_rst, 0);
    // R2 readback
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 start", d, 8'h1F);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 end", d, 8'h9F);
    wr(2'd3, 8'h15); rd(2'd3, d); chk("R2 end no enable", d, 8'h15);
    rd(2'd1, d); chk("R2 key reads 0", d, 0);

    // R5 late fault sweep, R7 pulse length and ignored key
    for (int e = 1; e <= 4; e++) begin
      setup(5'd0, e[4:0], 1'b1);
      ticks(e * ES - 1); chk("R5 before window end", wdt_rst, 0);
      ticks(1); chk("R5 late reset", wdt_rst, 1);
      rd(2'd0, d); chk("R5 late flag", d, 8'h01);
      ticks(RT - 1); chk("R7 still held", wdt_rst, 1);
      wr(2'd1, 8'h0A);
      ticks(1); chk("R7 released", wdt_rst, 0);
      ticks(e * ES - 1); chk("R7 recount low", wdt_rst, 0);
      ticks(1); chk("R7 recount fault", wdt_rst, 1);
    end

    // R6/R11 early window sweep
    for (int s = 1; s <= 3; s++) begin
      for (int el = 0; el <= 2 * s + 1; el++) begin
        bit early;
        early = el < 2 * s;
        setup(s[4:0], 5'd4, 1'b1);
        ticks(el);
        wr(2'd1, 8'h0A);
        if (early) begin
          chk("R6 early reset", wdt_rst, 1);
          rd(2'd0, d); chk("R6 early flag", d, 8'h02);
        end else begin
          chk("R11 in-window no reset", wdt_rst, 0);
          rd(2'd0, d); chk("R11 no flag", d, 0);
        end
      end
    end

    // R10 flag clearing
    setup(5'd2, 5'd4, 1'b1);
    ticks(1); wr(2'd1, 8'h0A);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R10 write 0 keeps", d, 8'h02);
    wr(2'd0, 8'h01); rd(2'd0, d); chk("R10 other bit keeps", d, 8'h02);
    wr(2'd0, 8'h02); rd(2'd0, d); chk("R10 cleared", d, 0);
    setup(5'd0, 5'd1, 1'b1);
    ticks(3); rd(2'd0, d); chk("R10 late set", d, 8'h01);
    wr(2'd0, 8'h01); rd(2'd0, d); chk("R10 late cleared", d, 0);

    // R3 wrong keys
    setup(5'd0, 5'd2, 1'b1);
    ticks(4);
    wr(2'd3, 8'h81);
    for (int k = 0; k < 16; k++) if (k != 10) wr(2'd1, {4'h0, k[3:0]});
    ticks(1); chk("R3 no restart", wdt_rst, 0);
    ticks(1); chk("R3 original limit", wdt_rst, 1);

    // R4 key with upper nibble, reload
    setup(5'd0, 5'd2, 1'b1);
    wr(2'd1, 8'hFA);
    ticks(5); wr(2'd3, 8'h81); wr(2'd1, 8'h3A);
    ticks(2); chk("R4 restarted", wdt_rst, 0);
    ticks(1); chk("R4 new limit", wdt_rst, 1);

    // R8 disabled wraps
    setup(5'd0, 5'd1, 1'b0);
    ticks(10); chk("R8 no reset", wdt_rst, 0);
    rd(2'd0, d); chk("R8 no flag", d, 0);
    wr(2'd3, 8'h81);
    ticks(1); chk("R8 wrapped count low", wdt_rst, 0);
    ticks(1); chk("R8 wrapped count fault", wdt_rst, 1);

    // R9 end zero
    setup(5'd3, 5'd0, 1'b1);
    ticks(1); wr(2'd1, 8'h0A); chk("R9 no early", wdt_rst, 0);
    ticks(200); chk("R9 no late", wdt_rst, 0);
    rd(2'd0, d); chk("R9 no flag", d, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule